// File: doc/BRIEF.md
# Serial Register Slave with Ascending Burst

This block sits between an external four-wire serial master and a byte-wide register bank. Every frame opens with one direction bit (1 = read, 0 = write) and a 15-bit register address, both sent MSB first. Data bytes follow. The block oversamples the serial pins with its own system clock, so SCLK must stay well below the system clock rate. It turns each completed data byte into a one-cycle write or read strobe on the register port.

A byte held inside the block, at register address 0x000, selects the frame mode. When that byte equals 0x3C, a frame keeps going after its first data byte: every further byte moves to the next higher address until chip select is released. For any other value, only the first data byte of a frame is used. A burst flag tells the register bank whether a strobe belongs to a plain single-byte access or to a later byte of a streamed frame. A plain access takes 24 SCLK cycles. A streamed write of ten bytes from 0x020 takes 96 cycles and covers 0x020 through 0x029.

Top module: `spi_stream_slave`

## Requirements
- R1: While `rst` is high and after it is released, `reg_we`, `reg_re`, `reg_burst` and `miso` are all 0 until a frame starts.
- R2: The slave samples MOSI on SCLK rising edges. Bit 15 of the header is the direction (0 = write) and bits 14..0 are the address. Each complete write byte produces exactly one single-cycle `reg_we` pulse, carrying that byte and its address.
- R3: For a read (direction bit 1), the slave pulses `reg_re` with the header address. It expects `reg_rdata` to be valid on the cycle after `reg_re`. It drives that byte on `miso` MSB first, changing after SCLK falling edges, so that the master can sample it on the next 8 rising edges.
- R4: A write to address 0x000 also stores the byte in the block. The byte can change only through such a write. A stored value of 0x3C enables streaming and any other value disables it. A read of 0x000 returns the stored byte on `miso`, not `reg_rdata`.
- R5: With streaming enabled, the Nth data byte of a write frame goes to header address + N − 1. Each byte produces its own strobe, so ten bytes from 0x020 write 0x020..0x029.
- R6: With streaming enabled, a read frame shifts out bytes from ascending addresses. The next address is read at the end of each byte.
- R7: With streaming disabled, data bytes after the first produce no strobe.
- R8: `reg_burst` goes high at the first SCLK rising edge of the second data byte of a streamed frame. It is 0 during the first byte's write strobe and returns to 0 after CS goes high.
- R9: If CS goes high in the middle of a byte, that byte produces no strobe. Bytes completed earlier in the frame are kept, and the next frame works normally.
- R10: The streaming address wraps from 0x7FFF to 0x0000.
- R11: The mode is fixed when a frame's header completes. A frame that writes 0x3C to 0x000 does not itself stream.
- R12: `reg_we` and `reg_re` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from master, idles low |
| cs_n | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data from master |
| miso | output | 1 | Serial data to master |
| reg_we | output | 1 | Register write strobe, one cycle |
| reg_re | output | 1 | Register read strobe, one cycle |
| reg_addr | output | 15 | Register address for the strobe |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data, valid the cycle after `reg_re` |
| reg_burst | output | 1 | High for non-first bytes of a streamed frame |

## Verification
Assertions check on every cycle that the write and read strobes never coincide and only follow a sampled SCLK rise inside an active frame. They also check that streamed write addresses ascend by one with wrap, that no strobe follows a non-streamed frame's first byte, that the burst flag is only high inside a frame, and that the mode byte changes only on its own write. Only the bench's scenarios can show that the bit order and header decode are right, that the serialized read data matches, and how the mode change is latched per frame. The same holds for abort recovery and for the exact address and data of each byte.

// File: rtl/spi_stream_pkg.sv
package spi_stream_pkg;

  // Frame decoding phase
  typedef enum logic [1:0] {
    PH_HDR,   // collecting direction bit and address
    PH_DATA,  // moving data bytes
    PH_SKIP   // non-streamed frame past its first byte
  } spi_phase_e;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_active,
  output logic mosi_s
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sclk_q;
  logic [SYNC_STAGES-1:0] csn_q;
  logic [SYNC_STAGES-1:0] mosi_q;
  logic                   sclk_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q    <= '0;
      csn_q     <= '1;
      mosi_q    <= '0;
      sclk_prev <= 1'b0;
    end else begin
      sclk_q    <= {sclk_q[SYNC_STAGES-2:0], sclk};
      csn_q     <= {csn_q[SYNC_STAGES-2:0], cs_n};
      mosi_q    <= {mosi_q[SYNC_STAGES-2:0], mosi};
      sclk_prev <= sclk_q[TOP];
    end
  end

  assign sclk_rise = sclk_q[TOP] & ~sclk_prev;
  assign sclk_fall = ~sclk_q[TOP] & sclk_prev;
  assign cs_active = ~csn_q[TOP];
  assign mosi_s    = mosi_q[TOP];

endmodule

// File: rtl/spi_stream_cfg.sv
module spi_stream_cfg #(
  parameter int          ADDR_W     = 15,
  parameter int          DATA_W     = 8,
  parameter int unsigned CFG_ADDR   = 0,
  parameter int unsigned STREAM_KEY = 'h3C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] cfg_q,
  output logic              stream_en
);

  logic cfg_we;
  assign cfg_we = wr_en && (wr_addr == ADDR_W'(CFG_ADDR));

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else if (cfg_we) cfg_q <= wr_data;
  end

  assign stream_en = (cfg_q == DATA_W'(STREAM_KEY));

  // R4
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_we) |-> $stable(cfg_q));

endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_stream_pkg::*;
#(
  parameter int          ADDR_W   = 15,
  parameter int          DATA_W   = 8,
  parameter int unsigned CFG_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              cs_active,
  input  logic              mosi_s,
  input  logic              stream_en,
  input  logic [DATA_W-1:0] cfg_rdata,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              reg_we,
  output logic              reg_re,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_burst,
  output logic              miso
);

  localparam int HDR_BITS = ADDR_W + 1;
  localparam int CNT_MAX  = (HDR_BITS > DATA_W) ? HDR_BITS : DATA_W;
  localparam int CNT_W    = $clog2(CNT_MAX);

  spi_phase_e        phase;
  logic [CNT_W-1:0]  cnt;
  logic [HDR_BITS-1:0] hdr_sr;
  logic [DATA_W-1:0] byte_sr;
  logic [DATA_W-1:0] tx_sr;
  logic [ADDR_W-1:0] cur_addr;
  logic              rd_mode;
  logic              stream_f;
  logic              more;
  logic              re_d;
  logic              from_cfg;

  logic [HDR_BITS-1:0] hdr_next;
  logic [DATA_W-1:0]   byte_next;
  logic [ADDR_W-1:0]   next_addr;

  assign hdr_next  = {hdr_sr[HDR_BITS-2:0], mosi_s};
  assign byte_next = {byte_sr[DATA_W-2:0], mosi_s};
  assign next_addr = cur_addr + ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_HDR;
      cnt       <= '0;
      hdr_sr    <= '0;
      byte_sr   <= '0;
      tx_sr     <= '0;
      cur_addr  <= '0;
      rd_mode   <= 1'b0;
      stream_f  <= 1'b0;
      more      <= 1'b0;
      re_d      <= 1'b0;
      from_cfg  <= 1'b0;
      reg_we    <= 1'b0;
      reg_re    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_burst <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      reg_re <= 1'b0;
      re_d   <= reg_re;
      if (!cs_active) begin
        phase     <= PH_HDR;
        cnt       <= '0;
        more      <= 1'b0;
        reg_burst <= 1'b0;
        tx_sr     <= '0;
      end else begin
        if (sclk_rise) begin
          unique case (phase)
            PH_HDR: begin
              hdr_sr <= hdr_next;
              if (cnt == CNT_W'(HDR_BITS - 1)) begin
                cnt      <= '0;
                phase    <= PH_DATA;
                rd_mode  <= hdr_next[HDR_BITS-1];
                cur_addr <= hdr_next[ADDR_W-1:0];
                stream_f <= stream_en;
                if (hdr_next[HDR_BITS-1]) begin
                  reg_re   <= 1'b1;
                  reg_addr <= hdr_next[ADDR_W-1:0];
                  from_cfg <= (hdr_next[ADDR_W-1:0] == ADDR_W'(CFG_ADDR));
                end
              end else begin
                cnt <= cnt + CNT_W'(1);
              end
            end
            PH_DATA: begin
              byte_sr <= byte_next;
              if (cnt == '0 && more) reg_burst <= 1'b1;
              if (cnt == CNT_W'(DATA_W - 1)) begin
                cnt <= '0;
                if (!rd_mode) begin
                  reg_we    <= 1'b1;
                  reg_addr  <= cur_addr;
                  reg_wdata <= byte_next;
                end
                if (stream_f) begin
                  more     <= 1'b1;
                  cur_addr <= next_addr;
                  if (rd_mode) begin
                    reg_re   <= 1'b1;
                    reg_addr <= next_addr;
                    from_cfg <= (next_addr == ADDR_W'(CFG_ADDR));
                  end
                end else begin
                  phase <= PH_SKIP;
                end
              end else begin
                cnt <= cnt + CNT_W'(1);
              end
            end
            default: ;
          endcase
        end
        if (re_d) begin
          tx_sr <= from_cfg ? cfg_rdata : reg_rdata;
        end else if (sclk_fall && phase != PH_HDR && (cnt != '0 || phase == PH_SKIP)) begin
          tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  assign miso = tx_sr[DATA_W-1];

  // Checker state: address of the most recent write strobe
  logic [ADDR_W-1:0] last_we_addr;
  always_ff @(posedge clk) begin
    if (rst) last_we_addr <= '0;
    else if (reg_we) last_we_addr <= reg_addr;
  end

  // R12
  we_re_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && reg_re));

  // R2
  strobe_src_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we || reg_re) |-> $past(sclk_rise && cs_active));

  // R5 R10
  ascend_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_burst) |-> (reg_addr == last_we_addr + ADDR_W'(1)));

  // R7
  skip_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(phase == PH_SKIP) |-> !(reg_we || reg_re));

  // R8
  burst_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    reg_burst |-> $past(cs_active));

endmodule

// File: rtl/spi_stream_slave.sv
module spi_stream_slave #(
  parameter int          ADDR_W      = 15,
  parameter int          DATA_W      = 8,
  parameter int          SYNC_STAGES = 2,
  parameter int unsigned CFG_ADDR    = 0,
  parameter int unsigned STREAM_KEY  = 'h3C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  output logic              reg_we,
  output logic              reg_re,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              reg_burst
);

  logic              sclk_rise;
  logic              sclk_fall;
  logic              cs_active;
  logic              mosi_s;
  logic              stream_en;
  logic [DATA_W-1:0] cfg_q;

  spi_pin_sync #(
    .SYNC_STAGES(SYNC_STAGES)
  ) sync_i (
    .clk       (clk),
    .rst       (rst),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .mosi      (mosi),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .cs_active (cs_active),
    .mosi_s    (mosi_s)
  );

  spi_stream_cfg #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .CFG_ADDR   (CFG_ADDR),
    .STREAM_KEY (STREAM_KEY)
  ) cfg_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (reg_we),
    .wr_addr   (reg_addr),
    .wr_data   (reg_wdata),
    .cfg_q     (cfg_q),
    .stream_en (stream_en)
  );

  spi_frame_ctrl #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CFG_ADDR (CFG_ADDR)
  ) frame_i (
    .clk       (clk),
    .rst       (rst),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .cs_active (cs_active),
    .mosi_s    (mosi_s),
    .stream_en (stream_en),
    .cfg_rdata (cfg_q),
    .reg_rdata (reg_rdata),
    .reg_we    (reg_we),
    .reg_re    (reg_re),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_burst (reg_burst),
    .miso      (miso)
  );

endmodule

// File: tb/spi_stream_slave_tb.sv
`timescale 1ns/1ps
module spi_stream_slave_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic        mosi = 1'b0;
  logic        miso;
  logic        reg_we, reg_re, reg_burst;
  logic [14:0] reg_addr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata = 8'h00;

  always #2 clk = ~clk;

  spi_stream_slave dut_i (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_burst(reg_burst)
  );

  function automatic logic [7:0] bank_val(input logic [14:0] a);
    return a[7:0] ^ 8'hA5;
  endfunction

  // Register bank model: data one cycle after the read strobe
  always @(posedge clk) if (reg_re) reg_rdata <= bank_val(reg_addr);

  logic [14:0] we_addr [32];
  logic [7:0]  we_data [32];
  logic        we_burst[32];
  logic [14:0] re_addr [32];
  int we_n = 0, re_n = 0, clash_n = 0;

  always @(negedge clk) begin
    if (reg_we && we_n < 32) begin
      we_addr[we_n] = reg_addr; we_data[we_n] = reg_wdata; we_burst[we_n] = reg_burst;
      we_n = we_n + 1;
    end
    if (reg_re && re_n < 32) begin
      re_addr[re_n] = reg_addr; re_n = re_n + 1;
    end
    if (reg_we && reg_re) clash_n = clash_n + 1;
  end

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] tx_bytes [16];
  logic [7:0] rx_bytes [16];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic d, output logic q);
    mosi = d;
    repeat (8) @(negedge clk);
    q = miso;
    sclk = 1'b1;
    repeat (8) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic spi_frame(input logic rw, input logic [14:0] addr,
                           input int nbytes, input int extra_bits);
    logic [15:0] hdr;
    logic        q;
    hdr = {rw, addr};
    @(posedge clk);
    we_n = 0; re_n = 0;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < 16; i++) send_bit(hdr[15-i], q);
    for (int b = 0; b < nbytes; b++) begin
      logic [7:0] r;
      for (int i = 0; i < 8; i++) begin
        send_bit(tx_bytes[b][7-i], q);
        r[7-i] = q;
      end
      rx_bytes[b] = r;
    end
    for (int i = 0; i < extra_bits; i++) send_bit(1'b1, q);
    repeat (8) @(negedge clk);
    cs_n = 1'b1;
    repeat (16) @(negedge clk);
  endtask

  // {rw, addr[14:0], data[7:0]}
  localparam logic [23:0] VEC [6] = '{
    {1'b0, 15'h0123, 8'h5A},
    {1'b0, 15'h7FFE, 8'hC3},
    {1'b0, 15'h0001, 8'h00},
    {1'b1, 15'h0123, 8'h00},
    {1'b1, 15'h0042, 8'h00},
    {1'b0, 15'h2AAA, 8'hFF}
  };

  initial begin
    repeat (4) @(negedge clk);
    // R1 during reset
    chk(!reg_we && !reg_re && !reg_burst && !miso, "R1 in reset", {reg_we, reg_re, reg_burst, miso}, 0);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    chk(!reg_we && !reg_re && !reg_burst && !miso, "R1 after reset", {reg_we, reg_re, reg_burst, miso}, 0);

    // Vector table: single accesses, streaming off (R2, R3)
    for (int v = 0; v < 6; v++) begin
      logic        rw;
      logic [14:0] a;
      logic [7:0]  d;
      {rw, a, d} = VEC[v];
      tx_bytes[0] = d;
      spi_frame(rw, a, 1, 0);
      if (!rw) begin
        chk(we_n == 1 && we_addr[0] == a && we_data[0] == d && !we_burst[0],
            "R2 write strobe", {we_n, we_addr[0], we_data[0]}, {1, a, d});
      end else begin
        chk(re_n == 1 && re_addr[0] == a, "R3 read strobe", re_addr[0], a);
        chk(rx_bytes[0] == bank_val(a), "R3 miso data", rx_bytes[0], bank_val(a));
      end
    end

    // R7: extra bytes ignored with streaming off
    tx_bytes[0] = 8'h11; tx_bytes[1] = 8'h22; tx_bytes[2] = 8'h33;
    spi_frame(1'b0, 15'h0040, 3, 0);
    chk(we_n == 1 && we_addr[0] == 15'h0040 && we_data[0] == 8'h11, "R7 one strobe", we_n, 1);

    // R11: enabling write does not stream its own frame
    tx_bytes[0] = 8'h3C; tx_bytes[1] = 8'h77;
    spi_frame(1'b0, 15'h0000, 2, 0);
    chk(we_n == 1 && we_addr[0] == 15'h0000, "R11 same frame not streamed", we_n, 1);

    // R4: read back of mode byte
    spi_frame(1'b1, 15'h0000, 1, 0);
    chk(rx_bytes[0] == 8'h3C, "R4 mode readback", rx_bytes[0], 8'h3C);

    // R5 / R8: 10-byte streamed write from 0x020
    for (int i = 0; i < 10; i++) tx_bytes[i] = 8'h10 + 8'(i);
    spi_frame(1'b0, 15'h0020, 10, 0);
    chk(we_n == 10, "R5 strobe count", we_n, 10);
    for (int i = 0; i < 10; i++) begin
      chk(we_addr[i] == 15'h0020 + 15'(i) && we_data[i] == 8'h10 + 8'(i),
          "R5 address/data", {we_addr[i], we_data[i]}, {15'h0020 + 15'(i), 8'h10 + 8'(i)});
      chk(we_burst[i] == (i != 0), "R8 burst flag", we_burst[i], (i != 0));
    end
    chk(!reg_burst, "R8 burst cleared after CS", reg_burst, 0);

    // R6: streamed read of 3 bytes from 0x0F0
    spi_frame(1'b1, 15'h00F0, 3, 0);
    for (int i = 0; i < 3; i++) begin
      chk(rx_bytes[i] == bank_val(15'h00F0 + 15'(i)), "R6 streamed read data",
          rx_bytes[i], bank_val(15'h00F0 + 15'(i)));
      chk(re_addr[i] == 15'h00F0 + 15'(i), "R6 read address", re_addr[i], 15'h00F0 + 15'(i));
    end

    // R10: wrap; second byte lands on 0x000, keep the enable value
    tx_bytes[0] = 8'hE1; tx_bytes[1] = 8'h3C;
    spi_frame(1'b0, 15'h7FFF, 2, 0);
    chk(we_n == 2 && we_addr[0] == 15'h7FFF && we_addr[1] == 15'h0000,
        "R10 address wrap", we_addr[1], 0);

    // R9: abort mid-byte, then a normal frame
    tx_bytes[0] = 8'hA1;
    spi_frame(1'b0, 15'h0300, 1, 3);
    chk(we_n == 1 && we_data[0] == 8'hA1, "R9 partial byte dropped", we_n, 1);
    tx_bytes[0] = 8'hB1; tx_bytes[1] = 8'hB2;
    spi_frame(1'b0, 15'h0050, 2, 0);
    chk(we_n == 2 && we_addr[1] == 15'h0051 && we_data[1] == 8'hB2, "R9 recovery", we_n, 2);

    // R4: a different value disables streaming
    tx_bytes[0] = 8'h11;
    spi_frame(1'b0, 15'h0000, 1, 0);
    tx_bytes[0] = 8'h61; tx_bytes[1] = 8'h62;
    spi_frame(1'b0, 15'h0060, 2, 0);
    chk(we_n == 1, "R4 streaming disabled", we_n, 1);

    // R12
    chk(clash_n == 0, "R12 strobes exclusive", clash_n, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule